// File: doc/BRIEF.md
# SPI Host Interrupt Error and Event Controller

This block collects the error and event conditions of a SPI host controller and drives two interrupt lines: one for errors and one for events. Each access strobe is inspected in the cycle it arrives: a command write, a read of the receive FIFO and a write to the transmit FIFO. Any fault it finds is recorded in a sticky status vector that software clears by writing ones. Each error class except the zero-byte-write class has its own enable bit. The enable decides only whether the class raises the error interrupt; the status bit is recorded either way.

Event conditions come from the FIFO occupancy counts and from the core's ready and active flags. The two watermark events are plain comparisons against programmable thresholds and follow their condition level. The other four events are edge-detected and held until acknowledged. The block also gates command writes on their way to the core. A command is forwarded only when it is well formed, the core is ready, and no error is pending.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After reset the error status and event status are all zero, both interrupts are low, and the block signal is low. The five error enables reset to 1, the event enables to 0, the TX threshold to 0 and the RX threshold to 127.
- R2: Error status bits are set one cycle after their strobe:
  - bit 0 for a command write while `ready_i` is low;
  - bit 1 for a TX write with a nonzero byte mask while `tx_depth_i` equals TX_DEPTH;
  - bit 2 for an RX read while `rx_depth_i` is 0;
  - bit 4 for a command whose chip-select index is not below NUM_CS;
  - bit 5 for a TX write with an all-zero byte mask.
- R3: `err_irq_o` is high when error status bit 5 is set, or when any status bit i (i from 0 to 4) is set together with enable bit i. Clearing an enable does not stop its status bit from being recorded.
- R4: Writing 1 to a bit of `err_clr_i` clears that status bit at the next edge. A new error of the same class in the same cycle wins over the clear.
- R5: A command is invalid, and sets status bit 3, when its speed code is 3, or when its direction code is 3 (both ways) with a speed code of 1 (dual) or 2 (quad). Direction codes: 0 dummy, 1 receive, 2 transmit, 3 both. Speed codes: 0 standard, 1 dual, 2 quad.
- R6: `cmd_fwd_o` follows `cmd_wr_i` in the same cycle only when `ready_i` is high, the command is valid, the chip-select index is in range and no error status bit is set. `cmd_block_o` is high while any error status bit is set.
- R7: Event status bit 3 is high while `tx_depth_i` is below the TX threshold. Event status bit 2 is high while `rx_depth_i` exceeds the RX threshold. Both follow their inputs in the same cycle.
- R8: Event status bits are latched on a transition, visible one cycle after it:
  - bit 5 when `active_i` falls;
  - bit 4 when `ready_i` rises;
  - bit 1 when `tx_depth_i` becomes 0;
  - bit 0 when `rx_depth_i` becomes RX_DEPTH.
  Each stays set until its acknowledge bit is written: `evt_ack_i` bit 0 for RX full, bit 1 for TX empty, bit 2 for ready, bit 3 for idle. A new transition in the acknowledge cycle wins.
- R9: `evt_irq_o` is the OR of the event status bits whose event enable bit is set. The enable bits are ordered RX full 0, TX empty 1, RX watermark 2, TX watermark 3, ready 4, idle 5.
- R10: A level already present when reset is released is not taken as a transition. This covers ready high, TX depth 0 and RX depth at RX_DEPTH.
- R11: Enable and threshold writes take effect on the edge at which their write strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_speed_i | input | 2 | Speed code of the command |
| cmd_dir_i | input | 2 | Direction code of the command |
| cmd_csid_i | input | CSID_W | Chip-select index of the command |
| tx_wr_i | input | 1 | TX FIFO write strobe |
| tx_be_i | input | BE_W | Byte mask of the TX write |
| rx_rd_i | input | 1 | RX FIFO read strobe |
| tx_depth_i | input | TXD_W | TX FIFO occupancy |
| rx_depth_i | input | RXD_W | RX FIFO occupancy |
| ready_i | input | 1 | Core ready for a command |
| active_i | input | 1 | Core executing a command |
| err_en_we_i | input | 1 | Error enable write strobe |
| err_en_wd_i | input | 5 | Error enable write data |
| evt_en_we_i | input | 1 | Event enable write strobe |
| evt_en_wd_i | input | 6 | Event enable write data |
| thr_we_i | input | 1 | Threshold write strobe |
| tx_thr_wd_i | input | TH_W | TX threshold write data |
| rx_thr_wd_i | input | TH_W | RX threshold write data |
| err_clr_i | input | 6 | Write-one-to-clear mask for error status |
| evt_ack_i | input | 4 | Acknowledge mask for latched edge events |
| err_irq_o | output | 1 | Error interrupt |
| evt_irq_o | output | 1 | Event interrupt |
| err_status_o | output | 6 | Error status |
| evt_status_o | output | 6 | Event status |
| cmd_fwd_o | output | 1 | Command accepted and passed to the core |
| cmd_block_o | output | 1 | Commands refused while an error is pending |

## Verification
The bench targets the cases where a clear and a new error, or an acknowledge and a new transition, land in the same cycle. A design that lets the clear win there loses an error or an event. It also checks that the zero-byte-write class raises the interrupt with every enable off; a design that gates it like the others stays silent. Commands sent while an earlier error is pending must not be forwarded. A design that looks only at the current command would pass them to the core. Finally, levels held high through reset must not appear as transitions, which a design with zero-initialised history registers would report.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  localparam int NUM_ERR = 6;
  localparam int NUM_EVT = 6;
  localparam int NUM_EDGE = 4;

  // error status bit positions (software decodes these)
  localparam int ERR_BUSY = 0;
  localparam int ERR_OVF  = 1;
  localparam int ERR_UNF  = 2;
  localparam int ERR_CMD  = 3;
  localparam int ERR_CSID = 4;
  localparam int ERR_ZB   = 5;

  // event status bit positions
  localparam int EVT_RXFULL = 0;
  localparam int EVT_TXEMP  = 1;
  localparam int EVT_RXWM   = 2;
  localparam int EVT_TXWM   = 3;
  localparam int EVT_READY  = 4;
  localparam int EVT_IDLE   = 5;

  typedef enum logic [1:0] {SPD_STD, SPD_DUAL, SPD_QUAD, SPD_RSVD} spd_e;
  typedef enum logic [1:0] {DIR_DUMMY, DIR_RX, DIR_TX, DIR_BOTH} dir_e;

  function automatic logic cmd_is_bad(input logic [1:0] spd, input logic [1:0] dir);
    spd_e s;
    dir_e d;
    s = spd_e'(spd);
    d = dir_e'(dir);
    return (s == SPD_RSVD) || ((d == DIR_BOTH) && (s != SPD_STD));
  endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int TH_W = 8,
  parameter int RX_THR_RST = 127
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            err_en_we_i,
  input  logic [4:0]      err_en_wd_i,
  input  logic            evt_en_we_i,
  input  logic [5:0]      evt_en_wd_i,
  input  logic            thr_we_i,
  input  logic [TH_W-1:0] tx_thr_wd_i,
  input  logic [TH_W-1:0] rx_thr_wd_i,
  output logic [4:0]      err_en_o,
  output logic [5:0]      evt_en_o,
  output logic [TH_W-1:0] tx_thr_o,
  output logic [TH_W-1:0] rx_thr_o
);

  logic [4:0]      err_en_q, err_en_d;
  logic [5:0]      evt_en_q, evt_en_d;
  logic [TH_W-1:0] tx_thr_q, tx_thr_d, rx_thr_q, rx_thr_d;

  always_comb begin
    err_en_d = err_en_q;
    evt_en_d = evt_en_q;
    tx_thr_d = tx_thr_q;
    rx_thr_d = rx_thr_q;
    if (err_en_we_i) err_en_d = err_en_wd_i;
    if (evt_en_we_i) evt_en_d = evt_en_wd_i;
    if (thr_we_i) begin
      tx_thr_d = tx_thr_wd_i;
      rx_thr_d = rx_thr_wd_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_en_q <= '1;
      evt_en_q <= '0;
      tx_thr_q <= '0;
      rx_thr_q <= TH_W'(RX_THR_RST);
    end else begin
      err_en_q <= err_en_d;
      evt_en_q <= evt_en_d;
      tx_thr_q <= tx_thr_d;
      rx_thr_q <= rx_thr_d;
    end
  end

  assign err_en_o = err_en_q;
  assign evt_en_o = evt_en_q;
  assign tx_thr_o = tx_thr_q;
  assign rx_thr_o = rx_thr_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_en_we_i |=> $stable(err_en_q)) else $error("err enable moved without write"); // R11

endmodule

// File: rtl/irq_err_unit.sv
module irq_err_unit
  import spi_irq_pkg::*;
#(
  parameter int NUM_CS   = 1,
  parameter int CSID_W   = 32,
  parameter int BE_W     = 4,
  parameter int TX_DEPTH = 72,
  parameter int TXD_W    = 7,
  parameter int RXD_W    = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_wr_i,
  input  logic [1:0]         cmd_speed_i,
  input  logic [1:0]         cmd_dir_i,
  input  logic [CSID_W-1:0]  cmd_csid_i,
  input  logic               tx_wr_i,
  input  logic [BE_W-1:0]    tx_be_i,
  input  logic               rx_rd_i,
  input  logic [TXD_W-1:0]   tx_depth_i,
  input  logic [RXD_W-1:0]   rx_depth_i,
  input  logic               ready_i,
  input  logic [NUM_ERR-1:0] clr_i,
  output logic [NUM_ERR-1:0] status_o,
  output logic               cmd_fwd_o,
  output logic               block_o
);

  logic [NUM_ERR-1:0] st_q, st_d, set;
  logic tx_full, rx_empty, zero_mask, csid_bad;

  always_comb begin
    tx_full   = (int'(tx_depth_i) == TX_DEPTH);
    rx_empty  = (rx_depth_i == '0);
    zero_mask = (tx_be_i == '0);
    csid_bad  = (cmd_csid_i >= CSID_W'(NUM_CS));

    set           = '0;
    set[ERR_BUSY] = cmd_wr_i & ~ready_i;
    set[ERR_OVF]  = tx_wr_i & ~zero_mask & tx_full;
    set[ERR_UNF]  = rx_rd_i & rx_empty;
    set[ERR_CMD]  = cmd_wr_i & cmd_is_bad(cmd_speed_i, cmd_dir_i);
    set[ERR_CSID] = cmd_wr_i & csid_bad;
    set[ERR_ZB]   = tx_wr_i & zero_mask;

    st_d = (st_q & ~clr_i) | set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign block_o   = |st_q;
  assign cmd_fwd_o = cmd_wr_i & ready_i & ~set[ERR_CMD] & ~set[ERR_CSID] & ~(|st_q);
  assign status_o  = st_q;

  AST_BUSY_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && !ready_i) |=> st_q[ERR_BUSY]) else $error("busy error lost"); // R2

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((st_q & $past(st_q & ~clr_i)) == $past(st_q & ~clr_i))) else $error("status dropped"); // R4

endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter bit RISE = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic ack_i,
  output logic flag_o
);

  logic prev_q, flag_q, flag_d, hit;

  always_comb begin
    hit    = RISE ? (lvl_i & ~prev_q) : (~lvl_i & prev_q);
    flag_d = hit | (flag_q & ~ack_i);
  end

  // history resets to the inactive-side value so reset release is no transition
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= RISE;
      flag_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  AST_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !ack_i) |=> flag_q) else $error("edge event lost"); // R8

endmodule

// File: rtl/irq_evt_unit.sv
module irq_evt_unit
  import spi_irq_pkg::*;
#(
  parameter int RX_DEPTH = 64,
  parameter int TXD_W    = 7,
  parameter int RXD_W    = 7,
  parameter int TH_W     = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [TXD_W-1:0]    tx_depth_i,
  input  logic [RXD_W-1:0]    rx_depth_i,
  input  logic                ready_i,
  input  logic                active_i,
  input  logic [TH_W-1:0]     tx_thr_i,
  input  logic [TH_W-1:0]     rx_thr_i,
  input  logic [NUM_EDGE-1:0] ack_i,
  output logic [NUM_EVT-1:0]  status_o
);

  localparam logic [NUM_EDGE-1:0] RISE_MASK = 4'b0111;

  logic [NUM_EDGE-1:0] lvl, flag;
  logic txwm, rxwm;

  always_comb begin
    lvl[0] = (int'(rx_depth_i) == RX_DEPTH);
    lvl[1] = (tx_depth_i == '0);
    lvl[2] = ready_i;
    lvl[3] = active_i;
    txwm   = int'(tx_depth_i) < int'(tx_thr_i);
    rxwm   = int'(rx_depth_i) > int'(rx_thr_i);
  end

  for (genvar g = 0; g < NUM_EDGE; g++) begin : g_edge
    irq_edge_latch #(.RISE(RISE_MASK[g])) u_lat (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i (lvl[g]),
      .ack_i (ack_i[g]),
      .flag_o(flag[g])
    );
  end

  always_comb begin
    status_o             = '0;
    status_o[EVT_RXFULL] = flag[0];
    status_o[EVT_TXEMP]  = flag[1];
    status_o[EVT_RXWM]   = rxwm;
    status_o[EVT_TXWM]   = txwm;
    status_o[EVT_READY]  = flag[2];
    status_o[EVT_IDLE]   = flag[3];
  end

endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int NUM_CS     = 1,
  parameter int CSID_W     = 32,
  parameter int BE_W       = 4,
  parameter int TX_DEPTH   = 72,
  parameter int RX_DEPTH   = 64,
  parameter int TH_W       = 8,
  parameter int RX_THR_RST = 127,
  localparam int TXD_W     = $clog2(TX_DEPTH + 1),
  localparam int RXD_W     = $clog2(RX_DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_wr_i,
  input  logic [1:0]         cmd_speed_i,
  input  logic [1:0]         cmd_dir_i,
  input  logic [CSID_W-1:0]  cmd_csid_i,
  input  logic               tx_wr_i,
  input  logic [BE_W-1:0]    tx_be_i,
  input  logic               rx_rd_i,
  input  logic [TXD_W-1:0]   tx_depth_i,
  input  logic [RXD_W-1:0]   rx_depth_i,
  input  logic               ready_i,
  input  logic               active_i,
  input  logic               err_en_we_i,
  input  logic [4:0]         err_en_wd_i,
  input  logic               evt_en_we_i,
  input  logic [5:0]         evt_en_wd_i,
  input  logic               thr_we_i,
  input  logic [TH_W-1:0]    tx_thr_wd_i,
  input  logic [TH_W-1:0]    rx_thr_wd_i,
  input  logic [5:0]         err_clr_i,
  input  logic [3:0]         evt_ack_i,
  output logic               err_irq_o,
  output logic               evt_irq_o,
  output logic [5:0]         err_status_o,
  output logic [5:0]         evt_status_o,
  output logic               cmd_fwd_o,
  output logic               cmd_block_o
);

  logic [4:0]      err_en;
  logic [5:0]      evt_en;
  logic [TH_W-1:0] tx_thr, rx_thr;

  irq_cfg_regs #(.TH_W(TH_W), .RX_THR_RST(RX_THR_RST)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .err_en_we_i(err_en_we_i),
    .err_en_wd_i(err_en_wd_i),
    .evt_en_we_i(evt_en_we_i),
    .evt_en_wd_i(evt_en_wd_i),
    .thr_we_i   (thr_we_i),
    .tx_thr_wd_i(tx_thr_wd_i),
    .rx_thr_wd_i(rx_thr_wd_i),
    .err_en_o   (err_en),
    .evt_en_o   (evt_en),
    .tx_thr_o   (tx_thr),
    .rx_thr_o   (rx_thr)
  );

  irq_err_unit #(
    .NUM_CS(NUM_CS), .CSID_W(CSID_W), .BE_W(BE_W),
    .TX_DEPTH(TX_DEPTH), .TXD_W(TXD_W), .RXD_W(RXD_W)
  ) u_err (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_wr_i   (cmd_wr_i),
    .cmd_speed_i(cmd_speed_i),
    .cmd_dir_i  (cmd_dir_i),
    .cmd_csid_i (cmd_csid_i),
    .tx_wr_i    (tx_wr_i),
    .tx_be_i    (tx_be_i),
    .rx_rd_i    (rx_rd_i),
    .tx_depth_i (tx_depth_i),
    .rx_depth_i (rx_depth_i),
    .ready_i    (ready_i),
    .clr_i      (err_clr_i),
    .status_o   (err_status_o),
    .cmd_fwd_o  (cmd_fwd_o),
    .block_o    (cmd_block_o)
  );

  irq_evt_unit #(
    .RX_DEPTH(RX_DEPTH), .TXD_W(TXD_W), .RXD_W(RXD_W), .TH_W(TH_W)
  ) u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_depth_i(tx_depth_i),
    .rx_depth_i(rx_depth_i),
    .ready_i   (ready_i),
    .active_i  (active_i),
    .tx_thr_i  (tx_thr),
    .rx_thr_i  (rx_thr),
    .ack_i     (evt_ack_i),
    .status_o  (evt_status_o)
  );

  // zero-byte class has no enable: its gate is tied high
  assign err_irq_o = |(err_status_o & {1'b1, err_en});
  assign evt_irq_o = |(evt_status_o & evt_en);

  AST_ZB_UNGATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_status_o[ERR_ZB] |-> err_irq_o) else $error("zero-byte irq missing"); // R3

  AST_NO_FWD_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_block_o |-> !cmd_fwd_o) else $error("command passed while blocked"); // R6

  AST_FWD_NEEDS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_fwd_o |-> ready_i) else $error("command passed while busy"); // R6

  AST_EVT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_en == '0) |-> !evt_irq_o) else $error("event irq with no enable"); // R9

endmodule

// File: tb/tb_spi_irq_ctrl.sv
module tb_spi_irq_ctrl;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_ni;
  logic cmd_wr; logic [1:0] spd, dir; logic [31:0] csid;
  logic tx_wr; logic [3:0] be; logic rx_rd;
  logic [6:0] txd, rxd;
  logic ready, active;
  logic ee_we; logic [4:0] ee_wd;
  logic ve_we; logic [5:0] ve_wd;
  logic th_we; logic [7:0] txt_wd, rxt_wd;
  logic [5:0] clr; logic [3:0] ack;
  logic err_irq, evt_irq, fwd, blk;
  logic [5:0] est, vst;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  spi_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_wr_i(cmd_wr), .cmd_speed_i(spd), .cmd_dir_i(dir), .cmd_csid_i(csid),
    .tx_wr_i(tx_wr), .tx_be_i(be), .rx_rd_i(rx_rd),
    .tx_depth_i(txd), .rx_depth_i(rxd), .ready_i(ready), .active_i(active),
    .err_en_we_i(ee_we), .err_en_wd_i(ee_wd), .evt_en_we_i(ve_we), .evt_en_wd_i(ve_wd),
    .thr_we_i(th_we), .tx_thr_wd_i(txt_wd), .rx_thr_wd_i(rxt_wd),
    .err_clr_i(clr), .evt_ack_i(ack),
    .err_irq_o(err_irq), .evt_irq_o(evt_irq), .err_status_o(est), .evt_status_o(vst),
    .cmd_fwd_o(fwd), .cmd_block_o(blk)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    cmd_wr = 0; tx_wr = 0; rx_rd = 0; ee_we = 0; ve_we = 0; th_we = 0; clr = 0; ack = 0;
  endtask

  task automatic send_cmd(input logic [1:0] s, input logic [1:0] d, input logic [31:0] c);
    cmd_wr = 1; spd = s; dir = d; csid = c;
  endtask

  task automatic clear_all();
    clr = 6'h3F; tick(); idle_inputs(); tick();
  endtask

  task automatic t_reset();
    chk("R1 err status", 32'(est), 0);
    chk("R1 evt status (R10 no edge at release)", 32'(vst), 0);
    chk("R1 irqs", {30'd0, err_irq, evt_irq}, 0);
    chk("R1 block", 32'(blk), 0);
  endtask

  task automatic t_fwd();
    send_cmd(2'd0, 2'd2, 0); #1;
    chk("R6 valid cmd forwarded", 32'(fwd), 1);
    tick(); idle_inputs();
    chk("R6 no error on valid cmd", 32'(est), 0);
  endtask

  task automatic t_busy();
    ready = 0; send_cmd(2'd0, 2'd1, 0); #1;
    chk("R6 busy cmd not forwarded", 32'(fwd), 0);
    tick(); idle_inputs(); ready = 1;
    chk("R2 busy sets bit0", 32'(est), 32'h01);
    chk("R3 busy irq with enable", 32'(err_irq), 1);
    chk("R6 block while error", 32'(blk), 1);
    send_cmd(2'd0, 2'd2, 0); #1;
    chk("R6 pending error blocks cmd", 32'(fwd), 0);
    tick(); idle_inputs();
    clr = 6'h01; tick(); idle_inputs();
    chk("R4 w1c clears", 32'(est), 0);
    ack = 4'b0100; tick(); idle_inputs();
  endtask

  task automatic t_invalid();
    send_cmd(2'd3, 2'd1, 0); #1;
    chk("R6 reserved speed not forwarded", 32'(fwd), 0);
    tick(); idle_inputs();
    chk("R5 speed 3 invalid", 32'(est), 32'h08);
    clear_all();
    send_cmd(2'd1, 2'd3, 0); tick(); idle_inputs();
    chk("R5 dual bidir invalid", 32'(est), 32'h08);
    clear_all();
    send_cmd(2'd2, 2'd3, 0); tick(); idle_inputs();
    chk("R5 quad bidir invalid", 32'(est), 32'h08);
    clear_all();
    send_cmd(2'd0, 2'd3, 0); #1;
    chk("R5 std bidir forwarded", 32'(fwd), 1);
    tick(); idle_inputs();
    send_cmd(2'd2, 2'd1, 0); tick(); idle_inputs();
    chk("R5 quad rx valid", 32'(est), 0);
  endtask

  task automatic t_csid();
    send_cmd(2'd0, 2'd2, 32'd1); #1;
    chk("R6 bad csid not forwarded", 32'(fwd), 0);
    tick(); idle_inputs();
    chk("R2 csid out of range bit4", 32'(est), 32'h10);
    clear_all();
  endtask

  task automatic t_fifo();
    txd = 7'd72; tx_wr = 1; be = 4'hF; tick(); idle_inputs();
    chk("R2 overflow bit1", 32'(est), 32'h02);
    clear_all();
    txd = 7'd0; tick();
    ack = 4'b0010; tick(); idle_inputs();
    rxd = 7'd0; rx_rd = 1; tick(); idle_inputs();
    chk("R2 underflow bit2", 32'(est), 32'h04);
    clear_all();
    tx_wr = 1; be = 4'h0; tick(); idle_inputs();
    chk("R2 zero-byte bit5", 32'(est), 32'h20);
    clear_all();
    rxd = 7'd5; rx_rd = 1; txd = 7'd3; tx_wr = 1; be = 4'h1; tick(); idle_inputs();
    chk("R2 legal accesses no error", 32'(est), 0);
    rxd = 7'd0; txd = 7'd0; tick(); ack = 4'b0010; tick(); idle_inputs();
  endtask

  task automatic t_gate();
    ee_we = 1; ee_wd = 5'd0; tick(); idle_inputs();
    ready = 0; send_cmd(2'd0, 2'd2, 0); tick(); idle_inputs(); ready = 1;
    chk("R3 disabled class still recorded", 32'(est), 32'h01);
    chk("R3 disabled class no irq", 32'(err_irq), 0);
    clear_all();
    tx_wr = 1; be = 4'h0; tick(); idle_inputs();
    chk("R3 zero-byte irq ignores enables", 32'(err_irq), 1);
    clear_all();
    ee_we = 1; ee_wd = 5'h04; tick(); idle_inputs();
    rx_rd = 1; tick(); idle_inputs();
    chk("R3 enable bit2 gates underflow", 32'(err_irq), 1);
    clear_all();
    ee_we = 1; ee_wd = 5'h1F; tick(); idle_inputs();
    ack = 4'b0100; tick(); idle_inputs();
  endtask

  task automatic t_setwins();
    ready = 0; send_cmd(2'd0, 2'd2, 0); tick();
    clr = 6'h01; tick(); idle_inputs(); ready = 1;
    chk("R4 new error wins over clear", 32'(est), 32'h01);
    clear_all();
    chk("R4 cleared after", 32'(est), 0);
    ack = 4'b0100; tick(); idle_inputs();
  endtask

  task automatic t_wm();
    th_we = 1; txt_wd = 8'd5; rxt_wd = 8'd3; txd = 7'd4; #1;
    chk("R11 threshold not yet applied", 32'(vst[3]), 0);
    tick(); idle_inputs();
    chk("R7 tx below threshold", 32'(vst[3]), 1);
    txd = 7'd5; #1;
    chk("R7 tx at threshold low", 32'(vst[3]), 0);
    rxd = 7'd4; #1;
    chk("R7 rx above threshold", 32'(vst[2]), 1);
    rxd = 7'd3; #1;
    chk("R7 rx at threshold low", 32'(vst[2]), 0);
    rxd = 7'd0; txd = 7'd0;
    th_we = 1; txt_wd = 8'd0; rxt_wd = 8'd127; tick(); idle_inputs();
    tick(); ack = 4'hF; tick(); idle_inputs();
  endtask

  task automatic t_edges();
    chk("R8 edges clear before test", 32'(vst), 0);
    ready = 0; tick(); ready = 1; tick();
    chk("R8 ready rise latched", 32'(vst[4]), 1);
    active = 1; tick(); active = 0; tick();
    chk("R8 active fall latched", 32'(vst[5]), 1);
    txd = 7'd3; tick(); txd = 7'd0; tick();
    chk("R8 tx empty latched", 32'(vst[1]), 1);
    rxd = 7'd64; tick();
    chk("R8 rx full latched, all edges", 32'(vst), 32'h33);
    tick();
    chk("R8 flags hold", 32'(vst), 32'h33);
    ack = 4'b1000; tick(); idle_inputs();
    chk("R8 ack idle only", 32'(vst), 32'h13);
    rxd = 7'd10; tick();
    rxd = 7'd64; ack = 4'b0001; tick(); idle_inputs();
    chk("R8 new edge wins over ack", 32'(vst[0]), 1);
  endtask

  task automatic t_evt_irq();
    chk("R9 no enables no irq", 32'(evt_irq), 0);
    ve_we = 1; ve_wd = 6'h10; tick(); idle_inputs();
    chk("R9 ready enable raises irq", 32'(evt_irq), 1);
    ve_we = 1; ve_wd = 6'h20; tick(); idle_inputs();
    chk("R9 idle enable with acked idle", 32'(evt_irq), 0);
    ve_we = 1; ve_wd = 6'h01; tick(); idle_inputs();
    chk("R9 rxfull enable bit0", 32'(evt_irq), 1);
    ack = 4'hF; ve_we = 1; ve_wd = 6'h08; th_we = 1; txt_wd = 8'd1; rxt_wd = 8'd127;
    tick(); idle_inputs();
    chk("R9 tx watermark enable bit3", 32'(evt_irq), 1);
    ve_we = 1; ve_wd = 6'h37; tick(); idle_inputs();
    chk("R9 other bits no irq", 32'(evt_irq), 0);
  endtask

  initial begin
    rst_ni = 0; idle_inputs();
    spd = 0; dir = 0; csid = 0; be = 4'hF; ee_wd = 0; ve_wd = 0; txt_wd = 0; rxt_wd = 0;
    txd = 7'd0; rxd = 7'd64; ready = 1; active = 0;
    repeat (3) tick();
    rst_ni = 1;
    tick();
    t_reset();
    rxd = 7'd0; tick();
    t_fwd();
    t_busy();
    t_invalid();
    t_csid();
    t_fifo();
    t_gate();
    t_setwins();
    t_wm();
    t_edges();
    t_evt_irq();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 20000 && !done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 20000);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule